// File: doc/BRIEF.md
# Pixel Clock Divider With Bypass

This block turns a fast reference clock into the timing for a display panel's pixel stream. It runs in one of two modes. In bypass mode it produces a pixel slot on every reference cycle. In divide mode it produces one slot every N reference cycles, with N an integer of two or more. It gives out a one-cycle clock enable for logic that runs on the reference clock, and a square-wave phase signal that a pad driver can forward as the panel clock.

The divisor sits in a control word as a biased value, the wanted divide minus two. That value is split into a low part and a high part, which are not next to each other in the word. Divide-by-one cannot be written through the divisor value at all and is reached only through the separate bypass input. A new setting is taken only when the running output period ends, so a change made part way through a period never yields a shortened pulse. The divisor in force is brought out so software can read back the rate actually produced.

Top module: `pix_clk_div`

## Requirements
- R1: While reset is held and in the cycles right after it, the block is in bypass mode: `div_eff_o` reads 1 and both `pix_en_o` and `pix_phase_o` are high.
- R2: In bypass mode (`bypass_i` = 1 when a period ends), `pix_en_o` and `pix_phase_o` stay high on every cycle and `div_eff_o` reads 1, whatever the divisor fields hold.
- R3: With `bypass_i` = 0 the effective divisor is F + 2. F is a 10-bit value: its bits 4:0 come from control-word bits 4:0 and its bits 9:5 come from control-word bits 31:27. Control-word bits 26:5 have no effect.
- R4: The effective divisor never exceeds 1023 (2 to the power 10, minus 1). F values of 1021, 1022 and 1023 all give 1023.
- R5: In divide mode `pix_en_o` is high for exactly one cycle per period of N reference cycles, on the last cycle of the period.
- R6: In divide mode `pix_phase_o` is high for the first floor(N/2) cycles of each period and low for the rest of it.
- R7: `bypass_i` and the control word are sampled only on the last cycle of a period. A change made earlier leaves the length of the current period and `div_eff_o` unchanged until that period ends.
- R8: `div_eff_o` reports the divisor of the period in progress (1 in bypass mode).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| bypass_i | input | 1 | 1 selects divide-by-one and ignores the divisor fields |
| ctrl_word_i | input | 32 | Control word holding the split, biased divisor fields |
| pix_en_o | output | 1 | One-cycle enable on the last reference cycle of each pixel period |
| pix_phase_o | output | 1 | Divided clock waveform, high for the first half of each period |
| div_eff_o | output | 10 | Divisor of the period in progress |

## Verification
The assertions assume that `bypass_i` and `ctrl_word_i` are the only controls, and that either may change on any cycle, including in the middle of a period. The properties therefore tie every change of the held divisor to a period end rather than to input timing. The stimulus table changes the inputs on the cycle that ends a period, so that each vector gives one clean, measured period. One directed test then rewrites the control word three cycles into an eight-cycle period, which exercises the mid-period case that the assertions guard. Control-word bits outside the two fields are set high in some vectors to show they have no effect.

// File: rtl/pcd_pkg.sv
package pcd_pkg;

   typedef enum logic {
      PCD_DIVIDE = 1'b0,
      PCD_BYPASS = 1'b1
   } pcd_mode_e;

   function automatic int pcd_max_div(input int fld_w);
      return (1 << fld_w) - 1;
   endfunction

endpackage

// File: rtl/pcd_field_decode.sv
module pcd_field_decode #(
   parameter int REG_W  = 32,
   parameter int LO_LSB = 0,
   parameter int LO_W   = 5,
   parameter int HI_LSB = 27,
   parameter int HI_W   = 5,
   localparam int FLD_W = LO_W + HI_W
) (
   input  logic                 bypass_i,
   input  logic [REG_W-1:0]     ctrl_word_i,
   output pcd_pkg::pcd_mode_e   mode_o,
   output logic [FLD_W-1:0]     div_o
);
   import pcd_pkg::*;

   localparam logic [FLD_W:0] MAX_DIV = (FLD_W+1)'(pcd_max_div(FLD_W));
   localparam logic [FLD_W:0] BIAS    = (FLD_W+1)'(2);

   logic [FLD_W-1:0] fld;
   logic [FLD_W:0]   sum;
   logic             unused_word;

   // the high part supplies the bits above the low part
   generate
      if (HI_W > 0) begin : g_split
         assign fld = {ctrl_word_i[HI_LSB +: HI_W], ctrl_word_i[LO_LSB +: LO_W]};
      end else begin : g_lo_only
         assign fld = ctrl_word_i[LO_LSB +: LO_W];
      end
   endgenerate

   assign unused_word = ^ctrl_word_i;

   always_comb begin
      sum = {1'b0, fld} + BIAS;
      if (sum > MAX_DIV) begin
         sum = MAX_DIV;
      end
      if (bypass_i) begin
         mode_o = PCD_BYPASS;
         div_o  = FLD_W'(1);
      end else begin
         mode_o = PCD_DIVIDE;
         div_o  = sum[FLD_W-1:0];
      end
   end

endmodule

// File: rtl/pcd_period_ctrl.sv
module pcd_period_ctrl #(
   parameter int DIV_W = 10
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  pcd_pkg::pcd_mode_e  mode_i,
   input  logic [DIV_W-1:0]    div_i,
   output logic                end_o,
   output logic [DIV_W-1:0]    cnt_o,
   output pcd_pkg::pcd_mode_e  cur_mode_o,
   output logic [DIV_W-1:0]    cur_div_o
);
   import pcd_pkg::*;

   localparam logic [DIV_W-1:0] MAX_DIV = DIV_W'(pcd_max_div(DIV_W));

   assign end_o = (cur_mode_o == PCD_BYPASS) || (cnt_o == cur_div_o - DIV_W'(1));

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cur_mode_o <= PCD_BYPASS;
         cur_div_o  <= DIV_W'(1);
         cnt_o      <= '0;
      end else if (end_o) begin
         cur_mode_o <= mode_i;
         cur_div_o  <= div_i;
         cnt_o      <= '0;
      end else begin
         cnt_o      <= cnt_o + DIV_W'(1);
      end
   end

   // R7: the held setting moves only right after a period end
   a_r7_hold_mid_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$past(end_o) |-> ($stable(cur_div_o) && $stable(cur_mode_o)));

   // R4: a divide setting stays inside 2..MAX
   a_r4_within_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cur_mode_o == PCD_DIVIDE) |-> (cur_div_o >= DIV_W'(2) && cur_div_o <= MAX_DIV));

   // R5: the counter never runs past the period
   a_r5_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cur_mode_o == PCD_DIVIDE) |-> (cnt_o < cur_div_o));

endmodule

// File: rtl/pcd_wave_gen.sv
module pcd_wave_gen #(
   parameter int DIV_W = 10
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                end_i,
   input  logic [DIV_W-1:0]    cnt_i,
   input  pcd_pkg::pcd_mode_e  cur_mode_i,
   input  logic [DIV_W-1:0]    cur_div_i,
   output logic                en_o,
   output logic                phase_o
);
   import pcd_pkg::*;

   logic [DIV_W-1:0] half;

   assign half    = cur_div_i >> 1;
   assign en_o    = end_i;
   assign phase_o = (cur_mode_i == PCD_BYPASS) || (cnt_i < half);

   // R6: a rising phase edge always follows the end of a period
   a_r6_rise_after_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(phase_o) |-> $past(en_o));

   // R6: the phase is low on the last cycle of a divided period
   a_r6_low_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_o && cur_mode_i == PCD_DIVIDE) |-> !phase_o);

endmodule

// File: rtl/pix_clk_div.sv
module pix_clk_div #(
   parameter int REG_W  = 32,
   parameter int LO_LSB = 0,
   parameter int LO_W   = 5,
   parameter int HI_LSB = 27,
   parameter int HI_W   = 5,
   localparam int FLD_W = LO_W + HI_W
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              bypass_i,
   input  logic [REG_W-1:0]  ctrl_word_i,
   output logic              pix_en_o,
   output logic              pix_phase_o,
   output logic [FLD_W-1:0]  div_eff_o
);
   import pcd_pkg::*;

   // elaboration-time parameter checks
   generate
      if (LO_W < 1) begin : g_bad_lo_w
         $error("low divisor part needs at least one bit");
      end
      if (FLD_W < 2) begin : g_bad_fld_w
         $error("divisor field must be at least two bits wide");
      end
      if (LO_LSB + LO_W > REG_W) begin : g_bad_lo_pos
         $error("low divisor part lies outside the control word");
      end
      if (HI_W > 0 && HI_LSB + HI_W > REG_W) begin : g_bad_hi_pos
         $error("high divisor part lies outside the control word");
      end
      if (HI_W > 0 && HI_LSB < LO_LSB + LO_W && LO_LSB < HI_LSB + HI_W) begin : g_overlap
         $error("divisor parts overlap");
      end
   endgenerate

   pcd_mode_e        nxt_mode;
   logic [FLD_W-1:0] nxt_div;
   logic             per_end;
   logic [FLD_W-1:0] cnt;
   pcd_mode_e        cur_mode;
   logic [FLD_W-1:0] cur_div;

   pcd_field_decode #(
      .REG_W (REG_W),
      .LO_LSB(LO_LSB),
      .LO_W  (LO_W),
      .HI_LSB(HI_LSB),
      .HI_W  (HI_W)
   ) u_decode (
      .bypass_i   (bypass_i),
      .ctrl_word_i(ctrl_word_i),
      .mode_o     (nxt_mode),
      .div_o      (nxt_div)
   );

   pcd_period_ctrl #(.DIV_W(FLD_W)) u_period (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .mode_i    (nxt_mode),
      .div_i     (nxt_div),
      .end_o     (per_end),
      .cnt_o     (cnt),
      .cur_mode_o(cur_mode),
      .cur_div_o (cur_div)
   );

   pcd_wave_gen #(.DIV_W(FLD_W)) u_wave (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .end_i     (per_end),
      .cnt_i     (cnt),
      .cur_mode_i(cur_mode),
      .cur_div_i (cur_div),
      .en_o      (pix_en_o),
      .phase_o   (pix_phase_o)
   );

   assign div_eff_o = cur_div;

   // R2: a reported divisor of one means a pulse and a high phase every cycle
   a_r2_bypass_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (div_eff_o == FLD_W'(1)) |-> (pix_en_o && pix_phase_o));

   // R5: after a divided period ends into another divided one, the enable drops
   a_r5_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pix_en_o && div_eff_o != FLD_W'(1) && !bypass_i) |=> !pix_en_o);

   // R3: a bypass request at a period end never yields a divisor above one
   a_r3_bypass_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pix_en_o && bypass_i) |=> (div_eff_o == FLD_W'(1)));

endmodule

// File: tb/pix_clk_div_tb.sv
module pix_clk_div_tb;

   localparam int NVEC  = 12;
   localparam int LIMIT = 150000;

   typedef struct packed {
      logic        byp;
      logic [31:0] word;
      logic [15:0] ndiv;
      logic [15:0] nhigh;
   } vec_t;

   // expected divisor and high time worked out from R2, R3, R4 and R6
   localparam vec_t VEC [NVEC] = '{
      '{1'b0, 32'h0000_0000, 16'd2,    16'd1},    // R3 F=0
      '{1'b0, 32'h07FF_FFE1, 16'd3,    16'd1},    // R3 bits 26:5 ignored
      '{1'b0, 32'h0000_0005, 16'd7,    16'd3},    // R6 odd
      '{1'b0, 32'h0000_0006, 16'd8,    16'd4},    // R6 even
      '{1'b1, 32'h0000_0009, 16'd1,    16'd1},    // R2 fields ignored
      '{1'b0, 32'h0800_0000, 16'd34,   16'd17},   // R3 high part lsb
      '{1'b0, 32'h0800_001F, 16'd65,   16'd32},   // R3 both parts
      '{1'b0, 32'hF800_0013, 16'd1013, 16'd506},  // R3 large
      '{1'b0, 32'hF800_001F, 16'd1023, 16'd511},  // R4 clamp
      '{1'b0, 32'hF800_001C, 16'd1022, 16'd511},  // R4 largest unclamped
      '{1'b0, 32'hF800_001D, 16'd1023, 16'd511},  // R4 clamp edge
      '{1'b1, 32'hFFFF_FFFF, 16'd1,    16'd1}     // R2 all ones ignored
   };

   logic        clk;
   logic        rst_n;
   logic        bypass;
   logic [31:0] word;
   logic        pix_en;
   logic        pix_phase;
   logic [9:0]  div_eff;

   int checks;
   int failures;
   int cyc;
   bit done;

   pix_clk_div u_dut (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .bypass_i   (bypass),
      .ctrl_word_i(word),
      .pix_en_o   (pix_en),
      .pix_phase_o(pix_phase),
      .div_eff_o  (div_eff)
   );

   initial clk = 1'b0;
   always #2 clk = ~clk;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // counts negedges up to and including the one showing the enable
   task automatic measure(output int period, output int high, output int eff);
      period = 0;
      high   = 0;
      eff    = -1;
      do begin
         @(negedge clk);
         period++;
         if (period == 1) eff = int'(div_eff);
         if (pix_phase) high++;
      end while (!pix_en && period < 4000);
   endtask

   initial begin
      cyc = 0;
      wait (cyc == LIMIT);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog actual=%0d expected=done", cyc);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      int per, hi, eff;
      checks   = 0;
      failures = 0;
      done     = 1'b0;
      rst_n    = 1'b0;
      bypass   = 1'b0;
      word     = 32'h0000_0006;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 div_eff in reset", int'(div_eff), 1);
      chk("R1 pix_en in reset", int'(pix_en), 1);
      chk("R1 pix_phase in reset", int'(pix_phase), 1);
      bypass = 1'b1;
      rst_n  = 1'b1;
      @(negedge clk);
      chk("R1 div_eff after reset", int'(div_eff), 1);
      chk("R1 pix_en after reset", int'(pix_en), 1);

      // table walk: inputs change on a period-end cycle
      for (int i = 0; i < NVEC; i++) begin
         bypass = VEC[i].byp;
         word   = VEC[i].word;
         measure(per, hi, eff);
         chk($sformatf("R8 R3 R4 divisor vec%0d", i), eff, int'(VEC[i].ndiv));
         chk($sformatf("R5 period vec%0d", i), per, int'(VEC[i].ndiv));
         chk($sformatf("R6 R2 high time vec%0d", i), hi, int'(VEC[i].nhigh));
      end

      // R7: change mid-period must not cut the period short
      bypass = 1'b0;
      word   = 32'h0000_0006;
      measure(per, hi, eff);
      chk("R7 setup period", per, 8);
      repeat (3) @(negedge clk);
      word = 32'h0000_0000;
      measure(per, hi, eff);
      chk("R7 remaining cycles", per, 5);
      chk("R7 divisor held mid-period", eff, 8);
      measure(per, hi, eff);
      chk("R7 new period after end", per, 2);
      chk("R7 R8 new divisor after end", eff, 2);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule